// File: doc/BRIEF.md
# Two-Channel Split-Count Pulse Generator

This block produces two independent pulse-width-modulated outputs. Each channel's waveform is set by two tick counts: one for the time spent high and one for the time spent low. The period is therefore the sum of the two counts, and no separate period and compare values are involved. Each channel picks one of four clock-enable tick inputs as its time base. It passes that through its own prescaler and its own gate before the ticks reach the phase counter.

Software programs the block through a small word-addressed register bus. There is one count word per channel and one shared control word. A channel starts with its high phase. It reloads its counts only at period boundaries. Clearing its run bit forces the output low at once. The low phase is never shorter than one tick. The block has no polarity control: an inverted waveform is obtained by swapping the two counts.

Top module: `pwm2_gen`

## Requirements
- R1: Byte offset 0x0 is channel 0's count word and 0x4 is channel 1's. In each, bits [15:0] are the low count and bits [31:16] the high count. Offset 0x8 is the control word. For channel c it holds: run bit at position c; 2-bit source select at bits [5+2c:4+2c]; 7-bit divider at bits [14+8c:8+8c]; gate bit at position 15+8c. All other control bits read 0. Offset 0xC reads 0 and ignores writes.
- R2: A running channel drives its output high for `hi` ticks, then low for `lo` ticks, and repeats. A period is tick-aligned and starts with the high phase.
- R3: The select field value s makes `src_tick[s]` the channel's time base.
- R4: A divider value N passes one tick to the channel for every N+1 selected source ticks. N=0 passes every tick.
- R5: With the gate bit cleared, the channel receives no ticks and its output holds its level.
- R6: Clearing the run bit drives the output low in the cycle after the write, without finishing the period. The output stays low while the bit is clear.
- R7: Setting the run bit again restarts the channel at the start of a full high phase.
- R8: A high count of 0 keeps the output low for the whole period.
- R9: A low count of 0 still gives a low phase of exactly one tick per period.
- R10: A count word written during a period affects the output only from the next period boundary.
- R11: The two channels are independent: channel 1's fields control only `pwm_out[1]`.
- R12: After reset, both outputs are low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_tick | input | 4 | Four clock-enable tick sources |
| pwm_out | output | 2 | Channel outputs, bit c for channel c |

## Verification
The bench goes after the degenerate counts: a zero high count must never pulse high, and a zero low count must still dip low for one tick rather than stay high. It writes new counts in mid-period: a design that reloads at once would cut the current high phase short. It clears the run bit in mid-high: a design that finishes the period first would keep the output high. Freezing by gate and by a silent source, the prescaler ratios, and restarting after re-enable are timed against cycle counts. A wrong divider relation, for example N instead of N+1, or a restart in the low phase, shows up as a wrong run length.

// File: rtl/pwm2_pkg.sv
// Shared constants and register-layout helpers for the two-channel pulse
// generator. Assumes a 32-bit data word and two channels whose control
// fields are packed into one word at the positions below.
package pwm2_pkg;
    localparam int NUM_CH  = 2;
    localparam int NUM_SRC = 4;
    localparam int CNT_W   = 16;
    localparam int DIV_W   = 7;
    localparam int SEL_W   = 2;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;

    // Bit position of channel c's run bit in the control word.
    function automatic int run_bit(input int c);
        return c;
    endfunction

    // Lowest bit of channel c's source-select field.
    function automatic int sel_lsb(input int c);
        return 4 + SEL_W * c;
    endfunction

    // Lowest bit of channel c's divider field.
    function automatic int div_lsb(input int c);
        return 8 + 8 * c;
    endfunction

    // Bit position of channel c's gate bit.
    function automatic int gate_bit(input int c);
        return 15 + 8 * c;
    endfunction
endpackage

// File: rtl/pwm2_regs.sv
// Register file: one count word per channel and one shared control word.
// Word index = addr[ADDR_W-1:2]; the low two address bits are ignored.
// Assumes NCH count words at indices 0..NCH-1 and the control word at NCH.
module pwm2_regs
    import pwm2_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int NCH = NUM_CH,
    parameter int CW  = CNT_W,
    parameter int DW  = DIV_W,
    parameter int SW  = SEL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic [NCH-1:0]          run_en,
    output logic [NCH-1:0]          gate_en,
    output logic [NCH-1:0][SW-1:0]  src_sel,
    output logic [NCH-1:0][DW-1:0]  div_val,
    output logic [NCH-1:0][CW-1:0]  hi_cnt,
    output logic [NCH-1:0][CW-1:0]  lo_cnt
);
    localparam int IDX_W = AW - 2;
    localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(NCH);

    logic [IDX_W-1:0] word_idx;
    logic             unused_lsb;

    assign word_idx   = addr[AW-1:2];
    assign unused_lsb = ^addr[1:0];

    // Capture writes into count words and the control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en  <= '0;
            gate_en <= '0;
            src_sel <= '0;
            div_val <= '0;
            hi_cnt  <= '0;
            lo_cnt  <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (word_idx == IDX_W'(c)) begin
                    hi_cnt[c] <= wdata[2*CW-1:CW];
                    lo_cnt[c] <= wdata[CW-1:0];
                end
                if (word_idx == CTRL_IDX) begin
                    run_en[c]  <= wdata[run_bit(c)];
                    gate_en[c] <= wdata[gate_bit(c)];
                    src_sel[c] <= wdata[sel_lsb(c) +: SW];
                    div_val[c] <= wdata[div_lsb(c) +: DW];
                end
            end
        end
    end

    // Assemble the read word for the addressed register.
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (word_idx == IDX_W'(c)) begin
                rdata[2*CW-1:CW] = hi_cnt[c];
                rdata[CW-1:0]    = lo_cnt[c];
            end
            if (word_idx == CTRL_IDX) begin
                rdata[run_bit(c)]           = run_en[c];
                rdata[gate_bit(c)]          = gate_en[c];
                rdata[sel_lsb(c) +: SW]     = src_sel[c];
                rdata[div_lsb(c) +: DW]     = div_val[c];
            end
        end
    end
endmodule

// File: rtl/pwm2_prescale.sv
// Per-channel time base: selects one of NSRC tick inputs, gates it and
// divides it by div+1. Output tick is a one-cycle pulse, combinational
// from the selected source. Assumes source ticks are clock enables.
module pwm2_prescale
    import pwm2_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int SW   = SEL_W,
    parameter int DW   = DIV_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate,
    input  logic [SW-1:0]   sel,
    input  logic [DW-1:0]   div,
    input  logic [NSRC-1:0] src_tick,
    output logic            tick
);
    logic          src_hit;
    logic [DW-1:0] div_cnt;

    assign src_hit = src_tick[sel];
    assign tick    = gate && src_hit && (div_cnt >= div);

    // Count selected source ticks; wrap when the divider limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || !gate) begin
            div_cnt <= '0;
        end else if (src_hit) begin
            div_cnt <= (div_cnt >= div) ? '0 : div_cnt + DW'(1);
        end
    end

    // R4
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (div_cnt == '0));
endmodule

// File: rtl/pwm2_chan.sv
// Phase counter for one channel: high for hi ticks, then low for
// max(lo,1) ticks, repeating. Counts are latched at start and at each
// period boundary. Assumes tick is a single-cycle enable.
module pwm2_chan
    import pwm2_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [CW-1:0] hi_cfg,
    input  logic [CW-1:0] lo_cfg,
    output logic          out
);
    localparam logic [CW:0] ONE = (CW+1)'(1);

    logic          running;
    logic          in_high;
    logic [CW-1:0] cnt;
    logic [CW-1:0] hi_q;
    logic [CW-1:0] lo_q;
    logic [CW-1:0] lo_eff;
    logic          high_done;
    logic          low_done;

    assign lo_eff    = (lo_q == '0) ? CW'(1) : lo_q;
    assign high_done = (({1'b0, cnt} + ONE) == {1'b0, hi_q});
    assign low_done  = (({1'b0, cnt} + ONE) == {1'b0, lo_eff});
    assign out       = running && en && in_high;

    // Start, advance and reload the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            in_high <= 1'b0;
            cnt     <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (!en) begin
            running <= 1'b0;
            in_high <= 1'b0;
            cnt     <= '0;
        end else if (!running) begin
            running <= 1'b1;
            hi_q    <= hi_cfg;
            lo_q    <= lo_cfg;
            in_high <= (hi_cfg != '0);
            cnt     <= '0;
        end else if (tick) begin
            if (in_high) begin
                if (high_done) begin
                    in_high <= 1'b0;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end else if (low_done) begin
                hi_q    <= hi_cfg;
                lo_q    <= lo_cfg;
                in_high <= (hi_cfg != '0);
                cnt     <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // R2
    high_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && in_high) |-> (cnt < hi_q));
    // R10
    boundary_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en && tick && !in_high && low_done)
            |=> ((hi_q == $past(hi_cfg)) && (lo_q == $past(lo_cfg))));
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en && !tick) |=> $stable(cnt));
    // R8
    zero_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (hi_q == '0)) |-> !in_high);
endmodule

// File: rtl/pwm2_gen.sv
// Top: register file plus one prescaler and one phase counter per
// channel. Assumes all inputs are synchronous to clk.
module pwm2_gen
    import pwm2_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [NUM_CH-1:0]  pwm_out
);
    logic [NUM_CH-1:0]            run_en;
    logic [NUM_CH-1:0]            gate_en;
    logic [NUM_CH-1:0][SEL_W-1:0] src_sel;
    logic [NUM_CH-1:0][DIV_W-1:0] div_val;
    logic [NUM_CH-1:0][CNT_W-1:0] hi_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0] lo_cnt;
    logic [NUM_CH-1:0]            ch_tick;

    pwm2_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .run_en  (run_en),
        .gate_en (gate_en),
        .src_sel (src_sel),
        .div_val (div_val),
        .hi_cnt  (hi_cnt),
        .lo_cnt  (lo_cnt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm2_prescale u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .gate     (gate_en[g]),
            .sel      (src_sel[g]),
            .div      (div_val[g]),
            .src_tick (src_tick),
            .tick     (ch_tick[g])
        );

        pwm2_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (run_en[g]),
            .tick   (ch_tick[g]),
            .hi_cfg (hi_cnt[g]),
            .lo_cfg (lo_cnt[g]),
            .out    (pwm_out[g])
        );

        // R6
        off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !run_en[g] |-> !pwm_out[g]);
    end
endmodule

// File: tb/pwm2_gen_bench.sv
module pwm2_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = 4'b0001;
    logic [1:0]  pwm_out;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pwm2_gen u_pwm2_gen (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_tick(src_tick), .pwm_out(pwm_out)
    );

    // Sources: bit0 every cycle, bit1 never, bit2 every 3rd, bit3 every 2nd.
    initial begin
        forever begin
            @(negedge clk);
            cyc = cyc + 1;
            src_tick = {(cyc % 2) == 0, (cyc % 3) == 0, 1'b0, 1'b1};
        end
    end

    // Stimulus vectors: {hi[47:32], lo[31:16], div[14:8], sel[1:0]} on channel 0.
    localparam logic [47:0] VEC [6] = '{
        {16'd5,  16'd3, 1'b0, 7'd0, 6'd0, 2'd0},
        {16'd1,  16'd1, 1'b0, 7'd0, 6'd0, 2'd0},
        {16'd20, 16'd0, 1'b0, 7'd0, 6'd0, 2'd0},
        {16'd3,  16'd2, 1'b0, 7'd2, 6'd0, 2'd0},
        {16'd2,  16'd4, 1'b0, 7'd0, 6'd0, 2'd2},
        {16'd4,  16'd1, 1'b0, 7'd1, 6'd0, 2'd3}
    };

    function automatic int src_period(input int s);
        case (s)
            0: return 1;
            2: return 3;
            3: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] ctrl(input int c, input bit run, input bit gate,
                                         input int sel, input int div);
        logic [31:0] w = '0;
        w[c] = run;
        w[15 + 8*c] = gate;
        w[4 + 2*c +: 2] = 2'(sel);
        w[8 + 8*c +: 7] = 7'(div);
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Count consecutive negedge samples at the given level, from now.
    task automatic run_len(input int ch, input bit lvl, output int n);
        n = 0;
        while (pwm_out[ch] == lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Align to a tick-aligned rising edge, then measure one period.
    task automatic measure(input int ch, output int h, output int l);
        int n;
        @(negedge clk);
        run_len(ch, 1'b1, n);
        run_len(ch, 1'b0, n);
        run_len(ch, 1'b1, h);
        run_len(ch, 1'b0, l);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int h, l, n, eh, el, hv, lv, dv, sv;
        bit held, lvl0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(pwm_out == 2'b00, "R12 outputs low", pwm_out, 0);
        for (int a = 0; a < 3; a++) begin
            rd(4'(a * 4), d);
            check(d == 0, "R12 register zero", d, 0);
        end

        // R1: register map readback
        wr(4'h0, 32'hA5A5_1234);
        wr(4'h4, 32'h0F0F_8001);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'h0, d); check(d == 32'hA5A5_1234, "R1 word 0x0", d, 32'hA5A5_1234);
        rd(4'h4, d); check(d == 32'h0F0F_8001, "R1 word 0x4", d, 32'h0F0F_8001);
        rd(4'h8, d); check(d == 32'h00FF_FFF3, "R1 control fields", d, 32'h00FF_FFF3);
        rd(4'hC, d); check(d == 0, "R1 unmapped reads 0", d, 0);
        wr(4'h8, 32'h0);

        // R2 R3 R4 R9: vector table on channel 0
        for (int i = 0; i < 6; i++) begin
            hv = int'(VEC[i][47:32]); lv = int'(VEC[i][31:16]);
            dv = int'(VEC[i][14:8]);  sv = int'(VEC[i][1:0]);
            eh = hv * (dv + 1) * src_period(sv);
            el = ((lv == 0) ? 1 : lv) * (dv + 1) * src_period(sv);
            wr(4'h8, 32'h0);
            wr(4'h0, {VEC[i][47:32], VEC[i][31:16]});
            wr(4'h8, ctrl(0, 1, 1, sv, dv));
            measure(0, h, l);
            check(h == eh, "R2/R3/R4 high run", h, eh);
            check(l == el, "R2/R4/R9 low run", l, el);
        end

        // R10: mid-period write applies at next boundary
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd4, 16'd4});
        wr(4'h8, ctrl(0, 1, 1, 0, 0));
        @(negedge clk);
        run_len(0, 1'b1, n);
        run_len(0, 1'b0, n);
        bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = {16'd2, 16'd6};
        @(negedge clk);
        bus_wr = 1'b0;
        run_len(0, 1'b1, h);
        h = h + 1;
        run_len(0, 1'b0, l);
        check(h == 4, "R10 current high kept", h, 4);
        check(l == 4, "R10 current low kept", l, 4);
        run_len(0, 1'b1, h);
        run_len(0, 1'b0, l);
        check(h == 2 && l == 6, "R10 new counts next period", h * 100 + l, 206);

        // R6: disable mid-high drops output at once
        wr(4'h0, {16'd10, 16'd10});
        measure(0, h, l);
        @(negedge clk);
        run_len(0, 1'b0, n);
        bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = ctrl(0, 0, 1, 0, 0);
        @(negedge clk);
        bus_wr = 1'b0;
        check(pwm_out[0] == 1'b0, "R6 immediate low", pwm_out[0], 0);
        held = 1;
        repeat (30) begin @(negedge clk); if (pwm_out[0]) held = 0; end
        check(held, "R6 stays low while off", !held, 0);

        // R7: re-enable restarts with a full high phase
        wr(4'h8, ctrl(0, 1, 1, 0, 0));
        n = 0;
        while (!pwm_out[0] && n < 3) begin @(negedge clk); n++; end
        run_len(0, 1'b1, h);
        check(h == 10, "R7 full first high", h, 10);

        // R8: zero high count never goes high
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd0, 16'd5});
        wr(4'h8, ctrl(0, 1, 1, 0, 0));
        held = 1;
        repeat (60) begin @(negedge clk); if (pwm_out[0]) held = 0; end
        check(held, "R8 zero high stays low", !held, 0);

        // R5: gate off freezes the output level
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd3, 16'd3});
        wr(4'h8, ctrl(0, 1, 1, 0, 0));
        repeat (7) @(negedge clk);
        wr(4'h8, ctrl(0, 1, 0, 0, 0));
        lvl0 = pwm_out[0]; held = 1;
        repeat (30) begin @(negedge clk); if (pwm_out[0] != lvl0) held = 0; end
        check(held, "R5 gate off holds level", !held, 0);
        wr(4'h8, ctrl(0, 1, 1, 0, 0));
        measure(0, h, l);
        check(h == 3 && l == 3, "R5 gate on resumes", h * 100 + l, 303);

        // R3: silent source gives no ticks, first high phase never ends
        wr(4'h8, 32'h0);
        wr(4'h8, ctrl(0, 1, 1, 1, 0));
        repeat (3) @(negedge clk);
        held = 1;
        repeat (40) begin @(negedge clk); if (!pwm_out[0]) held = 0; end
        check(held, "R3 silent source frozen high", !held, 0);

        // R11: channel 1 alone, channel 0 off
        wr(4'h8, 32'h0);
        wr(4'h4, {16'd3, 16'd5});
        wr(4'h8, ctrl(1, 1, 1, 3, 1));
        measure(1, h, l);
        check(h == 12, "R11 ch1 high run", h, 12);
        check(l == 20, "R11 ch1 low run", l, 20);
        check(pwm_out[0] == 1'b0, "R11 ch0 unaffected", pwm_out[0], 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule